// File: doc/BRIEF.md
# SD Command Path Controller

This block sends one SD/MMC command frame on the CMD line and, when asked, collects the card's reply. A command is made of a 6-bit index, a 32-bit argument and a 2-bit reply selector. A start pulse loads all three. The block then builds a 48-bit frame and shifts it out one bit per card-clock strobe. The frame holds a start bit, a transmitter bit, the index, the argument, a CRC7 and a stop bit. After the frame the block releases the line. If a reply is expected, it watches for a start bit, counts the reply in, checks its CRC and stores the result.

All sequencing is paced by `ck_stb`, a one-cycle pulse of the system clock that marks each card-clock period. Outside strobe cycles the block holds its state. Every command ends with exactly one outcome flag: sent, reply good, reply CRC fail or reply timeout. The flag stays set until the next command is accepted.

The state machine has four states:
- `ST_IDLE` moves to `ST_SEND` on an accepted start.
- `ST_SEND` moves, on its 48th strobe, to `ST_IDLE` when no reply is expected, or to `ST_WAIT` when one is.
- `ST_WAIT` moves to `ST_RECV` when a low bit is seen on a strobe, or to `ST_IDLE` on timeout.
- `ST_RECV` moves to `ST_IDLE` on the reply's last bit.

Top module: `sdcmd_path`

## Requirements
- R1: After reset: `busy`=0, `cmd_oe`=0, `cmd_out`=1, all four flags 0, `rsp_idx`=0 and `rsp_words`=0.
- R2: A `cmd_start` seen in idle sets `busy` on the next cycle. The frame then appears on `cmd_out`, one bit per strobe, with `cmd_oe`=1 for exactly 48 strobes. In line order the frame is: 0, 1, index MSB first, argument MSB first, CRC7 MSB first, 1. After the 48th strobe `cmd_oe` is 0.
- R3: The frame CRC7 uses polynomial x^7+x^3+1 with a zero start value. It covers the first 40 frame bits.
- R4: `rsp_type` 01 selects a 48-bit reply and 11 selects a 136-bit reply. 00 and 10 select no reply: `flag_sent` rises and `busy` falls right after the 48th frame strobe.
- R5: While waiting, each strobe with `cmd_in`=1 counts toward the timeout. After 64 such strobes `flag_timeout` is set and `busy` drops. A low start bit on the 64th strobe is still accepted as a reply.
- R6: A short reply is 48 bits. Line bits 2..7 go to `rsp_idx`. Bits 8..39 go to word 0, which is `rsp_words[127:96]`, MSB first. Words 1..3 are 0. A CRC7 over bits 0..39 is compared with bits 40..46.
- R7: A long reply is 136 bits. Line bits 8..135 fill `rsp_words[127:0]` MSB first. A CRC7 over bits 8..127 is compared with bits 128..134. Bits 2..7 are stored in `rsp_idx` and are not compared.
- R8: On a reply CRC match `flag_rsp_ok` is set, otherwise `flag_crc_fail`. Every command ends with exactly one flag set. All flags clear when a new command is accepted.
- R9: While `busy`=1, `cmd_start`, `cmd_idx`, `cmd_arg` and `rsp_type` have no effect on the command in progress.
- R10: `busy` stays high from the cycle after acceptance until the cycle in which the outcome flag appears.
- R11: In a cycle without `ck_stb`, neither the line value nor the progress of the command changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_stb | input | 1 | One-cycle pulse per card-clock period |
| cmd_start | input | 1 | Start request, taken only in idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | Reply selector: 01 short, 11 long, else none |
| cmd_in | input | 1 | CMD line value from the card |
| cmd_out | output | 1 | CMD line value driven to the card |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command in progress |
| rsp_idx | output | 6 | Stored reply index field |
| rsp_words | output | 128 | Reply words, word 0 in the top 32 bits |
| flag_sent | output | 1 | Frame sent, no reply expected |
| flag_rsp_ok | output | 1 | Reply received with good CRC |
| flag_crc_fail | output | 1 | Reply received with bad CRC |
| flag_timeout | output | 1 | No reply start within the timeout |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 32-bit argument, four 32-bit reply words and a 64-strobe timeout. With these values the exact timeout edge is cheap to reach, as are the 63-idle-strobe late start and the full 136-bit long reply. The strobe is spaced one idle cycle apart, so every hold-between-strobes interval is visible at the ports. Random commands, reply delays and CRC corruption are mixed with directed cases: the two no-reply selector codes, the timeout edge, and inputs changed while busy.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } cmd_state_t;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_SHORT,
        RSP_LONG
    } rsp_kind_t;

    // one serial step of CRC7, polynomial x^7 + x^3 + 1
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic rsp_kind_t decode_rsp(input logic [1:0] t);
        rsp_kind_t k;
        case (t)
            2'b01:   k = RSP_SHORT;
            2'b11:   k = RSP_LONG;
            default: k = RSP_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [ARG_W-1:0]        arg,
    output logic [IDX_W+ARG_W+9:0]  frame
);
    localparam int BODY_W = 2 + IDX_W + ARG_W;

    logic [BODY_W-1:0] body;
    logic [6:0]        crc;

    always_comb begin
        body = {2'b01, idx, arg};
        crc  = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            crc = crc7_step(crc, body[i]);
        end
        frame = {body, crc, 1'b1};
    end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 7'd0)) else $error("crc not cleared"); // R6
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire = en && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT)) else $error("timer out of range"); // R5
endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
    import sdcmd_pkg::*;
#(
    parameter int IDX_W           = 6,
    parameter int ARG_W           = 32,
    parameter int WORD_W          = 32,
    parameter int NUM_WORDS       = 4,
    parameter int TIMEOUT_STROBES = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ck_stb,
    input  logic                        cmd_start,
    input  logic [IDX_W-1:0]            cmd_idx,
    input  logic [ARG_W-1:0]            cmd_arg,
    input  logic [1:0]                  rsp_type,
    input  logic                        cmd_in,
    output logic                        cmd_out,
    output logic                        cmd_oe,
    output logic                        busy,
    output logic [IDX_W-1:0]            rsp_idx,
    output logic [NUM_WORDS*WORD_W-1:0] rsp_words,
    output logic                        flag_sent,
    output logic                        flag_rsp_ok,
    output logic                        flag_crc_fail,
    output logic                        flag_timeout
);
    localparam int HDR_BITS   = 2 + IDX_W;
    localparam int FRAME_BITS = HDR_BITS + ARG_W + 8;
    localparam int SHORT_BITS = HDR_BITS + WORD_W + 8;
    localparam int RX_W       = NUM_WORDS * WORD_W;
    localparam int LONG_BITS  = HDR_BITS + RX_W;
    localparam int CNT_W      = $clog2(LONG_BITS + 1);

    localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_POS    = CNT_W'(HDR_BITS);

    cmd_state_t state_q, state_d;
    rsp_kind_t  kind_q;

    logic [FRAME_BITS-1:0] frame_w;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [CNT_W-1:0]      bit_cnt;
    logic [IDX_W-1:0]      idx_sr;
    logic [RX_W-1:0]       rx_sr;
    logic [RX_W-1:0]       rx_sr_next;
    logic [6:0]            rx_crc;

    logic accept, tx_stb, last_tx, wait_hi, rx_start, rx_stb, rx_done, tout, crc_en;
    logic [CNT_W-1:0] rx_last, crc_lo;

    sdcmd_frame #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_frame (
        .idx   (cmd_idx),
        .arg   (cmd_arg),
        .frame (frame_w)
    );

    sdcmd_timer #(.LIMIT(TIMEOUT_STROBES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (last_tx),
        .en     (wait_hi),
        .expire (tout)
    );

    sdcmd_crc7 u_rx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_start),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (rx_crc)
    );

    // event decode
    assign accept     = (state_q == ST_IDLE) && cmd_start;
    assign tx_stb     = (state_q == ST_SEND) && ck_stb;
    assign last_tx    = tx_stb && (bit_cnt == TX_LAST);
    assign wait_hi    = (state_q == ST_WAIT) && ck_stb && cmd_in;
    assign rx_start   = (state_q == ST_WAIT) && ck_stb && !cmd_in;
    assign rx_stb     = (state_q == ST_RECV) && ck_stb;
    assign rx_last    = (kind_q == RSP_LONG) ? LONG_LAST : SHORT_LAST;
    assign crc_lo     = (kind_q == RSP_LONG) ? HDR_POS : CNT_W'(1);
    assign rx_done    = rx_stb && (bit_cnt == rx_last);
    assign crc_en     = rx_stb && (bit_cnt >= crc_lo) && (bit_cnt < rx_last);
    assign rx_sr_next = {rx_sr[RX_W-2:0], cmd_in};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_SEND;
            ST_SEND: if (last_tx) state_d = (kind_q == RSP_NONE) ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
                if (rx_start)  state_d = ST_RECV;
                else if (tout) state_d = ST_IDLE;
            end
            ST_RECV: if (rx_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // line and activity outputs
    always_comb begin
        cmd_oe  = 1'b0;
        cmd_out = 1'b1;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_SEND: begin
                cmd_oe  = 1'b1;
                cmd_out = tx_sr[FRAME_BITS-1];
            end
            ST_WAIT, ST_RECV: ;
            default: busy = 1'b0;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q        <= RSP_NONE;
            tx_sr         <= '1;
            bit_cnt       <= '0;
            idx_sr        <= '0;
            rx_sr         <= '0;
            rsp_idx       <= '0;
            rsp_words     <= '0;
            flag_sent     <= 1'b0;
            flag_rsp_ok   <= 1'b0;
            flag_crc_fail <= 1'b0;
            flag_timeout  <= 1'b0;
        end else begin
            if (accept) begin
                kind_q        <= decode_rsp(rsp_type);
                tx_sr         <= frame_w;
                bit_cnt       <= '0;
                flag_sent     <= 1'b0;
                flag_rsp_ok   <= 1'b0;
                flag_crc_fail <= 1'b0;
                flag_timeout  <= 1'b0;
            end
            if (tx_stb) begin
                tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (last_tx && kind_q == RSP_NONE) flag_sent <= 1'b1;
            if (tout) flag_timeout <= 1'b1;
            if (rx_start) bit_cnt <= CNT_W'(1);
            if (rx_stb) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt >= CNT_W'(2) && bit_cnt < HDR_POS)
                    idx_sr <= {idx_sr[IDX_W-2:0], cmd_in};
                if (bit_cnt >= HDR_POS)
                    rx_sr <= rx_sr_next;
            end
            if (rx_done) begin
                rsp_idx <= idx_sr;
                if (kind_q == RSP_LONG)
                    rsp_words <= rx_sr_next;
                else
                    rsp_words <= {rx_sr_next[WORD_W+7:8], {(RX_W-WORD_W){1'b0}}};
                if (rx_crc == 7'd0) flag_rsp_ok   <= 1'b1;
                else                flag_crc_fail <= 1'b1;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $onehot({flag_sent, flag_rsp_ok, flag_crc_fail, flag_timeout}))
        else $error("outcome flags not one-hot"); // R8
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ({flag_sent, flag_rsp_ok, flag_crc_fail, flag_timeout} == 4'b0))
        else $error("flags kept over new command"); // R8
    AST_RELEASE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(ck_stb)) else $error("line released off strobe"); // R2
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ck_stb) |=> ($stable(cmd_out) && busy)) else $error("moved without strobe"); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_oe && cmd_out)) else $error("line driven in idle"); // R1
endmodule

// File: tb/test_sdcmd_path.sv
`timescale 1ns/1ps
module test_sdcmd_path;
    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ck_stb = 1'b0;
    logic         cmd_start = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   rsp_type = '0;
    logic         cmd_in = 1'b1;
    logic         cmd_out, cmd_oe, busy;
    logic [5:0]   rsp_idx;
    logic [127:0] rsp_words;
    logic         flag_sent, flag_rsp_ok, flag_crc_fail, flag_timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(HALF) clk = ~clk;

    sdcmd_path i_sdcmd_path (
        .clk(clk), .rst_n(rst_n), .ck_stb(ck_stb), .cmd_start(cmd_start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_type(rsp_type), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .rsp_idx(rsp_idx),
        .rsp_words(rsp_words), .flag_sent(flag_sent), .flag_rsp_ok(flag_rsp_ok),
        .flag_crc_fail(flag_crc_fail), .flag_timeout(flag_timeout)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CRC7 by polynomial division with 7 appended zeros; line bit i is s[135-i]
    function automatic logic [6:0] ref_crc(input logic [135:0] s, input int lo, input int hi);
        logic [7:0] r;
        r = '0;
        for (int i = lo; i <= hi; i++) begin
            r = {r[6:0], s[135-i]};
            if (r[7]) r = r ^ 8'h89;
        end
        for (int i = 0; i < 7; i++) begin
            r = {r[6:0], 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] s;
        s = {2'b01, idx, arg, 96'b0};
        return {2'b01, idx, arg, ref_crc(s, 0, 39), 1'b1};
    endfunction

    function automatic logic [3:0] flags();
        return {flag_sent, flag_rsp_ok, flag_crc_fail, flag_timeout};
    endfunction

    task automatic step(input logic stb, input logic din);
        @(negedge clk);
        ck_stb = stb;
        cmd_in = din;
    endtask

    // issue a command and check the frame; poke drives inputs while busy
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] typ, input bit poke);
        logic [47:0] got, exp;
        int oe_bad, hold_bad;
        logic gap_val;
        @(negedge clk);
        cmd_start = 1'b1; cmd_idx = idx; cmd_arg = arg; rsp_type = typ; ck_stb = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", 128'(busy), 128'd1);
        chk(flags() == 4'b0, "R8 flags cleared on accept", 128'(flags()), 128'd0);
        exp = ref_frame(idx, arg);
        oe_bad = 0; hold_bad = 0; gap_val = 1'b0; got = '0;
        for (int k = 0; k < 48; k++) begin
            step(1'b1, 1'b1);
            got[47-k] = cmd_out;
            if (!cmd_oe) oe_bad++;
            if (k > 0 && cmd_out != gap_val) hold_bad++;
            step(1'b0, 1'b1);
            gap_val = cmd_out;
            if (poke && k < 40) begin
                cmd_start = 1'b1; cmd_idx = $urandom; cmd_arg = $urandom; rsp_type = ~typ;
            end else begin
                cmd_start = 1'b0;
            end
        end
        chk(got == exp, "R2/R3 frame bits", 128'(got), 128'(exp));
        chk(oe_bad == 0 && cmd_oe == 1'b0, "R2 drive window", 128'(oe_bad), 128'd0);
        chk(hold_bad == 0, "R11 hold between strobes", 128'(hold_bad), 128'd0);
        if (typ == 2'b00 || typ == 2'b10) begin
            chk(flags() == 4'b1000 && !busy, "R4 sent with no reply", 128'({busy, flags()}), 128'h08);
        end else begin
            chk(busy == 1'b1 && flags() == 4'b0, "R4 waiting for reply", 128'({busy, flags()}), 128'h10);
        end
    endtask

    task automatic respond(input logic [135:0] seq, input int nbits, input int delay);
        for (int d = 0; d < delay; d++) begin
            step(1'b1, 1'b1);
            step(1'b0, 1'b1);
        end
        for (int i = 0; i < nbits; i++) begin
            step(1'b1, seq[135-i]);
            step(1'b0, seq[135-i]);
        end
        step(1'b0, 1'b1);
    endtask

    function automatic logic [135:0] mk_short(input logic [5:0] ridx, input logic [31:0] pay, input bit bad);
        logic [135:0] s;
        s = {2'b00, ridx, pay, 7'b0, 1'b1, 88'b0};
        s[95:89] = ref_crc(s, 0, 39);
        if (bad) s[91] = ~s[91];
        return s;
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] data, input bit bad);
        logic [135:0] s;
        s = {2'b00, 6'h3F, data, 7'b0, 1'b1};
        s[7:1] = ref_crc(s, 8, 127);
        if (bad) s[4] = ~s[4];
        return s;
    endfunction

    task automatic run_reply(input logic [1:0] typ, input int delay, input bit bad, input string tag);
        logic [135:0] s;
        logic [3:0] ef;
        logic [31:0] p;
        logic [119:0] d;
        ef = bad ? 4'b0010 : 4'b0100;
        if (typ == 2'b01) begin
            p = $urandom;
            s = mk_short(6'($urandom), p, bad);
            respond(s, 48, delay);
            chk(rsp_words == {s[127:96], 96'b0}, {"R6 short words ", tag}, rsp_words, {s[127:96], 96'b0});
        end else begin
            d = {24'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
            s = mk_long(d, bad);
            respond(s, 136, delay);
            chk(rsp_words == s[127:0], {"R7 long words ", tag}, rsp_words, s[127:0]);
        end
        chk(rsp_idx == s[133:128], {"R6/R7 reply index ", tag}, 128'(rsp_idx), 128'(s[133:128]));
        chk(flags() == ef && !busy, {"R8 reply outcome ", tag}, 128'({busy, flags()}), 128'(ef));
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !cmd_oe && cmd_out && flags() == 4'b0 && rsp_idx == 0 && rsp_words == 0,
            "R1 reset state", 128'({busy, cmd_oe, cmd_out, flags()}), 128'h10);

        // R4 both no-reply codes
        issue(6'd0, 32'h0, 2'b00, 1'b0);
        issue(6'h3F, 32'hFFFF_FFFF, 2'b10, 1'b0);

        // R9 inputs changed while busy, short reply good
        issue(6'd17, 32'h1234_5678, 2'b01, 1'b1);
        run_reply(2'b01, 3, 1'b0, "poked");

        // R5 timeout exactly at 64 idle strobes
        issue(6'd8, 32'hCAFE_0001, 2'b01, 1'b0);
        respond('0, 0, 63);
        chk(busy && flags() == 4'b0, "R5 still waiting after 63", 128'({busy, flags()}), 128'h10);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk(!busy && flags() == 4'b0001, "R5 timeout flag", 128'({busy, flags()}), 128'h01);

        // R5 start bit on the 64th strobe accepted, long reply
        issue(6'd2, 32'h0, 2'b11, 1'b0);
        run_reply(2'b11, 63, 1'b0, "late start");

        // R7 long reply with bad CRC, R6 short reply with bad CRC
        issue(6'd9, 32'hA5A5_5A5A, 2'b11, 1'b0);
        run_reply(2'b11, 0, 1'b1, "long bad");
        issue(6'd13, 32'h0F0F_F0F0, 2'b01, 1'b0);
        run_reply(2'b01, 1, 1'b1, "short bad");

        // random mix
        for (int n = 0; n < 14; n++) begin
            logic [1:0] t;
            t = 2'($urandom);
            issue(6'($urandom), $urandom, t, ($urandom % 3) == 0);
            if (t == 2'b01 || t == 2'b11)
                run_reply(t, int'($urandom % 20), ($urandom % 4) == 0, "random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule